// File: doc/BRIEF.md
# Stack Pointer Control Unit

This block owns the 16-bit stack pointer of a small 8-bit processor. Each clock the sequencer issues one 3-bit command. The command can leave the pointer alone, return it to its top-of-stack value, load it from the low register pair, step it for a pop or a push, or run the stack-move instruction. The pointer is driven straight out as the stack memory address. Instruction decode, the stack memory and the register file all sit outside this block. The block takes the register pair and the status byte as inputs.

A parameter selects how the stack-move instruction behaves. With the parameter off, the instruction only resets the pointer to its default. With it on, bit 4 of the status byte (a general-purpose flag) picks the direction:
- When the flag is high, the pointer is loaded from the register pair.
- When the flag is low, the pointer is copied out so the register file can store it into the same pair. The pointer itself does not change.

Software uses this to save and restore pointers when it switches between tasks. The block has no flag outputs, so neither form can alter a status flag.

Top module: `stack_ptr_unit`

## Requirements
- R1: A synchronous active-high reset loads the pointer with RESET_VAL (default 0x03FF) and clears the copy-out strobe `xfer_valid`.
- R2: Command 1 (clear) loads RESET_VAL on the next rising edge.
- R3: Command 2 (set) loads {`pair_hi`, `pair_lo`}, with `pair_hi` as the high byte.
- R4: Command 4 (push) decrements the pointer by one. 0x0000 wraps to 0xFFFF, and no error is reported.
- R5: Command 3 (pop) increments the pointer by one. 0xFFFF wraps to 0x0000.
- R6: Command 0 (idle) and the unused codes 6 and 7 leave the pointer unchanged and raise no strobe.
- R7: With MOVE_EN = 0, command 5 (stack move) loads RESET_VAL whatever the status byte holds, and raises no strobe.
- R8: With MOVE_EN = 1 and status bit 4 = 1, command 5 loads {`pair_hi`, `pair_lo`}.
- R9: With MOVE_EN = 1 and status bit 4 = 0, command 5 leaves the pointer unchanged. One cycle later it presents the old pointer on {`xfer_hi`, `xfer_lo`} with `xfer_valid` high.
- R10: Only bit 4 of the status byte steers command 5. The other seven bits have no effect.
- R11: `xfer_valid` is high for exactly the one cycle after a copy-out. `xfer_hi`/`xfer_lo` keep the last copied value until the next copy-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Pointer command: 0 idle, 1 clear, 2 set, 3 pop, 4 push, 5 stack move |
| pair_lo | input | 8 | Low register of the pair (R0) |
| pair_hi | input | 8 | High register of the pair (R1) |
| status | input | 8 | Status byte; bit 4 steers the stack move |
| sp_addr | output | 16 | Current stack pointer, used as stack memory address |
| xfer_valid | output | 1 | Copy-out strobe toward the register pair |
| xfer_lo | output | 8 | Copied pointer, low byte |
| xfer_hi | output | 8 | Copied pointer, high byte |

## Verification
The pointer register drives `sp_addr` directly, so a wrong next-value selection appears at the port on the very edge after the command. A carry bug in the wrap cases of push or pop, or a swapped byte order on load, shows up within one cycle. A fault in the stack-move steering needs two views to be caught. The bench watches whether the pointer moved, and it also watches the copy-out strobe and data one cycle later. Both parameter settings run side by side from the same stimulus, so a divergence between them is visible on the same edge.

// File: rtl/spu_pkg.sv
package spu_pkg;
  // Command codes seen on the cmd port
  localparam logic [2:0] CMD_IDLE  = 3'd0;
  localparam logic [2:0] CMD_CLEAR = 3'd1;
  localparam logic [2:0] CMD_SET   = 3'd2;
  localparam logic [2:0] CMD_POP   = 3'd3;
  localparam logic [2:0] CMD_PUSH  = 3'd4;
  localparam logic [2:0] CMD_MOVE  = 3'd5;

  // Resolved pointer operation after the move instruction is steered
  typedef enum logic [2:0] {
    PTR_HOLD,
    PTR_RESET,
    PTR_LOAD,
    PTR_INC,
    PTR_DEC
  } ptr_op_e;

  // Status bit that chooses the direction of the stack move
  localparam int XFER_FLAG_BIT = 4;
endpackage

// File: rtl/spu_cmd_resolve.sv
module spu_cmd_resolve
  import spu_pkg::*;
#(
  parameter bit MOVE_EN = 1'b0,
  parameter int FLAG_W  = 8
) (
  input  logic [2:0]        cmd,
  input  logic [FLAG_W-1:0] status,
  output ptr_op_e           op,
  output logic              copy_out
);
  logic dir_load;
  assign dir_load = status[XFER_FLAG_BIT];

  ptr_op_e move_op;
  logic    move_copy;

  generate
    if (MOVE_EN) begin : g_move_on
      always_comb begin
        move_op   = dir_load ? PTR_LOAD : PTR_HOLD;
        move_copy = ~dir_load;
      end
    end else begin : g_move_off
      always_comb begin
        move_op   = PTR_RESET;
        move_copy = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    op       = PTR_HOLD;
    copy_out = 1'b0;
    case (cmd)
      CMD_CLEAR: op = PTR_RESET;
      CMD_SET:   op = PTR_LOAD;
      CMD_POP:   op = PTR_INC;
      CMD_PUSH:  op = PTR_DEC;
      CMD_MOVE: begin
        op       = move_op;
        copy_out = move_copy;
      end
      default:   op = PTR_HOLD;
    endcase
  end
endmodule

// File: rtl/spu_next_ptr.sv
module spu_next_ptr
  import spu_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RESET_VAL = 16'h03FF
) (
  input  ptr_op_e       op,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    case (op)
      PTR_RESET: nxt = RESET_VAL;
      PTR_LOAD:  nxt = load_val;
      PTR_INC:   nxt = cur + ONE;
      PTR_DEC:   nxt = cur - ONE;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/spu_ptr_reg.sv
module spu_ptr_reg #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] RESET_VAL = 16'h03FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= nxt;
  end
endmodule

// File: rtl/spu_xfer_reg.sv
module spu_xfer_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          copy_out,
  input  logic [AW-1:0] cur,
  output logic          valid,
  output logic [AW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= copy_out;
      if (copy_out) data <= cur;
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int DW                = 8,
  parameter bit MOVE_EN           = 1'b0,
  parameter logic [2*DW-1:0] RESET_VAL = 16'h03FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cmd,
  input  logic [DW-1:0]   pair_lo,
  input  logic [DW-1:0]   pair_hi,
  input  logic [DW-1:0]   status,
  output logic [2*DW-1:0] sp_addr,
  output logic            xfer_valid,
  output logic [DW-1:0]   xfer_lo,
  output logic [DW-1:0]   xfer_hi
);
  localparam int AW = 2 * DW;

  ptr_op_e       op;
  logic          copy_out;
  logic [AW-1:0] nxt;
  logic [AW-1:0] cur;
  logic [AW-1:0] xfer_data;

  spu_cmd_resolve #(.MOVE_EN(MOVE_EN), .FLAG_W(DW)) u_resolve (
    .cmd      (cmd),
    .status   (status),
    .op       (op),
    .copy_out (copy_out)
  );

  spu_next_ptr #(.AW(AW), .RESET_VAL(RESET_VAL)) u_next (
    .op       (op),
    .cur      (cur),
    .load_val ({pair_hi, pair_lo}),
    .nxt      (nxt)
  );

  spu_ptr_reg #(.AW(AW), .RESET_VAL(RESET_VAL)) u_ptr (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .q   (cur)
  );

  spu_xfer_reg #(.AW(AW)) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .copy_out (copy_out),
    .cur      (cur),
    .valid    (xfer_valid),
    .data     (xfer_data)
  );

  assign sp_addr = cur;
  assign xfer_hi = xfer_data[AW-1:DW];
  assign xfer_lo = xfer_data[DW-1:0];
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int DW                = 8,
  parameter bit MOVE_EN           = 1'b0,
  parameter logic [2*DW-1:0] RESET_VAL = 16'h03FF
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cmd,
  input logic [DW-1:0]   pair_lo,
  input logic [DW-1:0]   pair_hi,
  input logic [DW-1:0]   status,
  input logic [2*DW-1:0] sp_addr,
  input logic            xfer_valid,
  input logic [DW-1:0]   xfer_lo,
  input logic [DW-1:0]   xfer_hi
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (sp_addr == RESET_VAL && !xfer_valid));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd1 |=> sp_addr == RESET_VAL);

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd2 |=> sp_addr == {$past(pair_hi), $past(pair_lo)});

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd4 |=> sp_addr == $past(sp_addr) - 1'b1);

  assert_pop_inc_R5: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd3 |=> sp_addr == $past(sp_addr) + 1'b1);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> $stable(sp_addr));

  assert_strobe_only_after_move_R11: assert property (@(posedge clk) disable iff (rst)
    cmd != 3'd5 |=> !xfer_valid);

  generate
    if (MOVE_EN) begin : g_on
      assert_move_load_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd5 && status[4]) |=> sp_addr == {$past(pair_hi), $past(pair_lo)} && !xfer_valid);
      assert_move_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd5 && !status[4]) |=>
          ($stable(sp_addr) && xfer_valid && {xfer_hi, xfer_lo} == $past(sp_addr)));
    end else begin : g_off
      assert_move_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd5 |=> (sp_addr == RESET_VAL && !xfer_valid));
    end
  endgenerate
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
  .DW(DW), .MOVE_EN(MOVE_EN), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .pair_lo(pair_lo), .pair_hi(pair_hi),
  .status(status), .sp_addr(sp_addr), .xfer_valid(xfer_valid),
  .xfer_lo(xfer_lo), .xfer_hi(xfer_hi)
);

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [7:0]  pair_lo = 8'h00;
  logic [7:0]  pair_hi = 8'h00;
  logic [7:0]  status = 8'h00;

  logic [15:0] sp_a, sp_b;
  logic        xv_a, xv_b;
  logic [7:0]  xlo_a, xhi_a, xlo_b, xhi_b;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  stack_ptr_unit #(.MOVE_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .pair_lo(pair_lo), .pair_hi(pair_hi),
    .status(status), .sp_addr(sp_a), .xfer_valid(xv_a),
    .xfer_lo(xlo_a), .xfer_hi(xhi_a)
  );

  stack_ptr_unit #(.MOVE_EN(1'b0)) u_dut_fixed (
    .clk(clk), .rst(rst), .cmd(cmd), .pair_lo(pair_lo), .pair_hi(pair_hi),
    .status(status), .sp_addr(sp_b), .xfer_valid(xv_b),
    .xfer_lo(xlo_b), .xfer_hi(xhi_b)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Apply one command for one edge, then sample at the following falling edge
  task automatic step(input logic [2:0] c, input logic [15:0] pair, input logic [7:0] st);
    cmd     = c;
    pair_hi = pair[15:8];
    pair_lo = pair[7:0];
    status  = st;
    @(posedge clk);
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sp after reset", sp_a, 16'h03FF);
    check("R1 fixed sp after reset", sp_b, 16'h03FF);
    check("R1 strobe low after reset", {15'd0, xv_a}, 16'd0);
    rst = 1'b0;
  endtask

  task automatic t_set;
    step(3'd2, 16'h1234, 8'h00);
    check("R3 set hi:lo", sp_a, 16'h1234);
    check("R3 set fixed", sp_b, 16'h1234);
  endtask

  task automatic t_push_wrap;
    step(3'd2, 16'h0001, 8'h00);
    step(3'd4, 16'h0000, 8'h00);
    check("R4 push dec", sp_a, 16'h0000);
    step(3'd4, 16'h0000, 8'h00);
    check("R4 push wrap", sp_a, 16'hFFFF);
  endtask

  task automatic t_pop_wrap;
    step(3'd3, 16'h0000, 8'h00);
    check("R5 pop wrap", sp_a, 16'h0000);
    step(3'd3, 16'h0000, 8'h00);
    check("R5 pop inc", sp_a, 16'h0001);
  endtask

  task automatic t_idle;
    step(3'd2, 16'h5A5A, 8'h00);
    step(3'd0, 16'h1111, 8'hFF);
    check("R6 idle hold", sp_a, 16'h5A5A);
    step(3'd6, 16'h2222, 8'hFF);
    check("R6 code 6 hold", sp_a, 16'h5A5A);
    step(3'd7, 16'h3333, 8'h00);
    check("R6 code 7 hold", sp_a, 16'h5A5A);
    check("R6 no strobe", {15'd0, xv_a}, 16'd0);
  endtask

  task automatic t_clear;
    step(3'd1, 16'hAAAA, 8'h00);
    check("R2 clear", sp_a, 16'h03FF);
    check("R2 clear fixed", sp_b, 16'h03FF);
  endtask

  task automatic t_move_load;
    step(3'd2, 16'h0100, 8'h00);
    step(3'd5, 16'hBEEF, 8'h10);
    check("R8 move load", sp_a, 16'hBEEF);
    check("R8 no strobe on load", {15'd0, xv_a}, 16'd0);
    check("R7 fixed move resets", sp_b, 16'h03FF);
    check("R7 fixed no strobe", {15'd0, xv_b}, 16'd0);
  endtask

  task automatic t_move_copy;
    step(3'd5, 16'h1111, 8'h00);
    check("R9 copy keeps sp", sp_a, 16'hBEEF);
    check("R9 strobe", {15'd0, xv_a}, 16'd1);
    check("R9 copied data", {xhi_a, xlo_a}, 16'hBEEF);
    step(3'd0, 16'h0000, 8'h00);
    check("R11 strobe one cycle", {15'd0, xv_a}, 16'd0);
    check("R11 data held", {xhi_a, xlo_a}, 16'hBEEF);
  endtask

  task automatic t_flag_mask;
    step(3'd5, 16'h7777, 8'hEF);
    check("R10 other bits set, bit4 low copies", sp_a, 16'hBEEF);
    check("R10 copy strobe", {15'd0, xv_a}, 16'd1);
    step(3'd5, 16'h2222, 8'hFF);
    check("R10 all bits set loads", sp_a, 16'h2222);
    step(3'd5, 16'h3333, 8'h10);
    check("R10 bit4 alone loads", sp_a, 16'h3333);
    step(3'd2, 16'h4444, 8'h00);
    step(3'd5, 16'h5555, 8'hEF);
    check("R7 fixed ignores status", sp_b, 16'h03FF);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_set();
    t_push_wrap();
    t_pop_wrap();
    t_idle();
    t_clear();
    t_move_load();
    t_move_copy();
    t_flag_mask();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule